// File: doc/BRIEF.md
# Memory ECC First/Next Error Logger

This block sits beside a memory datapath's ECC checker and turns its error pulses into state that software can read. Each error type, correctable and uncorrectable, has its own bit in two status bytes. The "first" byte marks that an error of that type has been seen. The "next" byte marks that at least one more error of that type arrived while the first was still held. Only the first error of each type loads its log: the 4 KiB block address for both types, and the syndrome as well for a correctable error. The log then stays frozen until software clears the matching first bit.

The checker supplies the failing block number, which is system address bits 33:12, together with each event pulse. Software reads and clears the status bytes through a byte-addressed register port, using write-one-to-clear. A level interrupt stays high while any status bit is set. The block also reports which of the two data channels the held correctable syndrome points at.

Top module: `dram_err_logger`

## Requirements
- R1: After reset, both status bytes read 0, all three logs read 0, `irq` is 0 and `ce_channel` is 0.
- R2: A correctable event seen while first bit 0 is clear sets first bit 0 on the next clock edge. In the same cycle it loads the correctable address log, which reads at offset 0xA0 as block bits in 27:6 with bits 31:28 and 5:0 zero. It also loads the syndrome log, which reads at 0xD0 in bits 15:0.
- R3: An uncorrectable event seen while first bit 1 is clear sets first bit 1 and loads the uncorrectable address log. That log reads at 0xB0 with the same layout as in R2.
- R4: An event of a type whose first bit is already set sets that type's bit in the next byte (0x82) and leaves that type's logs unchanged.
- R5: Writing the first byte at offset 0x80 clears each bit 1:0 written as 1 and leaves each bit written as 0 unchanged. Writes to offsets other than 0x80 and 0x82 change nothing.
- R6: Writing the next byte at offset 0x82 clears its bits 1:0 with the same write-one-to-clear rule.
- R7: When an event and a clear of the same status bit fall in the same cycle, the event wins and the bit is set afterwards. An event arriving while its first bit is being cleared goes to the next byte.
- R8: A correctable and an uncorrectable event in the same cycle are each recorded as if they had arrived alone.
- R9: `irq` is 1 exactly when any bit of either status byte is set.
- R10: `ce_channel` is derived from the logged syndrome, tested in this order:
  - if the upper byte is zero, the channel is 0;
  - otherwise, if the lower byte is zero, the channel is 1;
  - otherwise, if bits 15:12 or bits 11:8 are zero, the channel is 0;
  - otherwise the channel is 1.
- R11: Status bytes read with bits 7:2 as zero. Reading any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_evt | input | 1 | Correctable error pulse, one per cycle |
| ce_blk | input | 22 | Block number of the correctable error (address bits 33:12) |
| ce_syndrome | input | 16 | Syndrome of the correctable error |
| ue_evt | input | 1 | Uncorrectable error pulse |
| ue_blk | input | 22 | Block number of the uncorrectable error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 2 | Write-one-to-clear mask for status bits 1:0 |
| reg_rdata | output | 32 | Combinational read data at `reg_addr` |
| irq | output | 1 | High while any status bit is set |
| ce_channel | output | 1 | Channel decoded from the logged syndrome |

## Verification
The first directed patterns are single correctable and single uncorrectable events. These separate first-error capture from the next-error path and show whether a log changes on a repeated event. Further patterns combine an event with a clear of the same bit, and a correctable event with an uncorrectable one in the same cycle; these separate set priority from type independence. A set of syndromes reaches each of the four decode branches, including an all-zero syndrome. A long pseudo-random mix of events and clears to both status bytes is then checked every cycle against a behavioural model, across all readable offsets.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
  localparam int NTYPE    = 2;       // bit 0 correctable, bit 1 uncorrectable
  localparam int T_CE     = 0;
  localparam int T_UE     = 1;
  localparam int REG_W    = 32;
  localparam int OFS_W    = 8;
  localparam int BLK_LSB  = 6;       // block number position inside an address log word
  localparam logic [OFS_W-1:0] OFS_FIRST  = 8'h80;
  localparam logic [OFS_W-1:0] OFS_NEXT   = 8'h82;
  localparam logic [OFS_W-1:0] OFS_CE_ADR = 8'hA0;
  localparam logic [OFS_W-1:0] OFS_UE_ADR = 8'hB0;
  localparam logic [OFS_W-1:0] OFS_CE_SYN = 8'hD0;
endpackage

// File: rtl/err_flag_reg.sv
module err_flag_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] d;
  logic         en;

  // set has priority over clear
  always_comb begin
    d  = (q_o & ~clr_i) | set_i;
    en = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= '0;
    else if (en) q_o <= d;
  end
endmodule

// File: rtl/err_log_reg.sv
module err_log_reg #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/err_chan_dec.sv
module err_chan_dec #(
  parameter int SYN_W = 16
) (
  input  logic [SYN_W-1:0] syn_i,
  output logic             chan_o
);
  localparam int HALF = SYN_W / 2;
  localparam int QTR  = SYN_W / 4;

  logic hi_zero, lo_zero, top_q_zero, sub_q_zero;

  always_comb begin
    hi_zero    = (syn_i[SYN_W-1:HALF] == '0);
    lo_zero    = (syn_i[HALF-1:0] == '0);
    top_q_zero = (syn_i[SYN_W-1:SYN_W-QTR] == '0);
    sub_q_zero = (syn_i[SYN_W-QTR-1:HALF] == '0);
    if (hi_zero)                       chan_o = 1'b0;
    else if (lo_zero)                  chan_o = 1'b1;
    else if (top_q_zero || sub_q_zero) chan_o = 1'b0;
    else                               chan_o = 1'b1;
  end
endmodule

// File: rtl/dram_err_logger.sv
module dram_err_logger
  import err_log_pkg::*;
#(
  parameter int BLK_W = 22,
  parameter int SYN_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_evt,
  input  logic [BLK_W-1:0]        ce_blk,
  input  logic [SYN_W-1:0]        ce_syndrome,
  input  logic                    ue_evt,
  input  logic [BLK_W-1:0]        ue_blk,
  input  logic                    reg_wr,
  input  logic [OFS_W-1:0]        reg_addr,
  input  logic [NTYPE-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    irq,
  output logic                    ce_channel
);
  localparam int ADR_PAD = REG_W - BLK_W - BLK_LSB;

  logic [NTYPE-1:0] evt, first_q, next_q;
  logic [NTYPE-1:0] first_set, next_set, first_clr, next_clr;
  logic [BLK_W-1:0] blk_in [NTYPE];
  logic [BLK_W-1:0] blk_q  [NTYPE];
  logic [SYN_W-1:0] syn_q;

  always_comb begin
    evt        = {ue_evt, ce_evt};
    blk_in[T_CE] = ce_blk;
    blk_in[T_UE] = ue_blk;
    first_set  = evt & ~first_q;
    next_set   = evt & first_q;
    first_clr  = (reg_wr && reg_addr == OFS_FIRST) ? reg_wdata : '0;
    next_clr   = (reg_wr && reg_addr == OFS_NEXT)  ? reg_wdata : '0;
  end

  err_flag_reg #(.W(NTYPE)) u_first (
    .clk(clk), .rst_n(rst_n), .set_i(first_set), .clr_i(first_clr), .q_o(first_q));

  err_flag_reg #(.W(NTYPE)) u_next (
    .clk(clk), .rst_n(rst_n), .set_i(next_set), .clr_i(next_clr), .q_o(next_q));

  // one block-address log per error type
  for (genvar t = 0; t < NTYPE; t++) begin : g_blk
    err_log_reg #(.W(BLK_W)) u_blk (
      .clk(clk), .rst_n(rst_n), .load_i(first_set[t]), .d_i(blk_in[t]), .q_o(blk_q[t]));
  end

  err_log_reg #(.W(SYN_W)) u_syn (
    .clk(clk), .rst_n(rst_n), .load_i(first_set[T_CE]), .d_i(ce_syndrome), .q_o(syn_q));

  err_chan_dec #(.SYN_W(SYN_W)) u_chan (.syn_i(syn_q), .chan_o(ce_channel));

  always_comb begin
    irq = |{first_q, next_q};
    case (reg_addr)
      OFS_FIRST:  reg_rdata = {{(REG_W-NTYPE){1'b0}}, first_q};
      OFS_NEXT:   reg_rdata = {{(REG_W-NTYPE){1'b0}}, next_q};
      OFS_CE_ADR: reg_rdata = {{ADR_PAD{1'b0}}, blk_q[T_CE], {BLK_LSB{1'b0}}};
      OFS_UE_ADR: reg_rdata = {{ADR_PAD{1'b0}}, blk_q[T_UE], {BLK_LSB{1'b0}}};
      OFS_CE_SYN: reg_rdata = {{(REG_W-SYN_W){1'b0}}, syn_q};
      default:    reg_rdata = '0;
    endcase
  end

  // first correctable event captures bit and log
  assert_ce_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !first_q[T_CE]) |=> (first_q[T_CE] && blk_q[T_CE] == $past(ce_blk)
                                    && syn_q == $past(ce_syndrome)));

  assert_ue_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && !first_q[T_UE]) |=> (first_q[T_UE] && blk_q[T_UE] == $past(ue_blk)));

  // repeat event goes to next byte, log frozen
  assert_ce_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && first_q[T_CE]) |=> (next_q[T_CE] && $stable(blk_q[T_CE]) && $stable(syn_q)));

  assert_ue_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && first_q[T_UE]) |=> (next_q[T_UE] && $stable(blk_q[T_UE])));

  assert_first_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_FIRST && reg_wdata[T_CE] && !ce_evt) |=> !first_q[T_CE]);

  assert_next_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && first_q[T_UE] && reg_wr && reg_addr == OFS_NEXT) |=> next_q[T_UE]);
endmodule

// File: tb/sim_dram_err_logger.sv
`timescale 1ns/1ps
module sim_dram_err_logger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce_evt, ue_evt, reg_wr;
  logic [21:0] ce_blk, ue_blk;
  logic [15:0] ce_syndrome;
  logic [7:0]  reg_addr;
  logic [1:0]  reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, ce_channel;

  int vectors = 0;
  int fails   = 0;

  // reference state
  logic [1:0]  m_first, m_next;
  logic [21:0] m_ceblk, m_ueblk;
  logic [15:0] m_syn;

  always #4 clk = ~clk;

  dram_err_logger u0 (
    .clk(clk), .rst_n(rst_n), .ce_evt(ce_evt), .ce_blk(ce_blk), .ce_syndrome(ce_syndrome),
    .ue_evt(ue_evt), .ue_blk(ue_blk), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .ce_channel(ce_channel));

  function automatic logic ref_chan(input logic [15:0] s);
    if (s[15:8] == 8'h00) return 1'b0;
    if (s[7:0] == 8'h00)  return 1'b1;
    if (s[15:12] == 4'h0 || s[11:8] == 4'h0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // compares all observable state against the model
  task automatic check_all(input string tag);
    read_chk(8'h80, {30'b0, m_first}, {tag, " R5 first byte"});
    read_chk(8'h82, {30'b0, m_next},  {tag, " R6 next byte"});
    read_chk(8'hA0, {4'b0, m_ceblk, 6'b0}, {tag, " R2 ce log"});
    read_chk(8'hB0, {4'b0, m_ueblk, 6'b0}, {tag, " R3 ue log"});
    read_chk(8'hD0, {16'b0, m_syn}, {tag, " R2 syndrome"});
    read_chk(8'h84, 32'h0, {tag, " R11 unmapped"});
    chk({tag, " R9 irq"}, {31'b0, irq}, {31'b0, ((m_first | m_next) != 2'b00)});
    chk({tag, " R10 channel"}, {31'b0, ce_channel}, {31'b0, ref_chan(m_syn)});
  endtask

  task automatic step(input string tag, input logic ce, input logic [21:0] cb, input logic [15:0] sy,
                      input logic ue, input logic [21:0] ub,
                      input logic wr, input logic [7:0] wa, input logic [1:0] wd);
    logic [1:0] ev, clr_f, clr_n, nf, nn;
    @(negedge clk);
    ce_evt = ce; ce_blk = cb; ce_syndrome = sy; ue_evt = ue; ue_blk = ub;
    reg_wr = wr; reg_addr = wa; reg_wdata = wd;
    ev    = {ue, ce};
    clr_f = (wr && wa == 8'h80) ? wd : 2'b00;
    clr_n = (wr && wa == 8'h82) ? wd : 2'b00;
    nf = m_first; nn = m_next;
    for (int t = 0; t < 2; t++) begin
      if (ev[t] && !m_first[t]) begin
        nf[t] = 1'b1;
        if (t == 0) begin m_ceblk = cb; m_syn = sy; end
        else m_ueblk = ub;
      end else begin
        if (clr_f[t]) nf[t] = 1'b0;
      end
      if (ev[t] && m_first[t]) nn[t] = 1'b1;
      else if (clr_n[t]) nn[t] = 1'b0;
    end
    @(posedge clk);
    #1;
    m_first = nf; m_next = nn;
    ce_evt = 0; ue_evt = 0; reg_wr = 0;
    check_all(tag);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; ce_evt = 0; ue_evt = 0; reg_wr = 0;
    ce_blk = '0; ue_blk = '0; ce_syndrome = '0; reg_addr = '0; reg_wdata = '0;
    m_first = '0; m_next = '0; m_ceblk = '0; m_ueblk = '0; m_syn = '0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk);
    rst_n = 1;

    step("R2 first ce",      1, 22'h3ABCDE, 16'h00A5, 0, 0, 0, 0, 0);
    step("R4 repeat ce",     1, 22'h111111, 16'h7777, 0, 0, 0, 0, 0);
    step("R3 first ue",      0, 0, 0, 1, 22'h2F0F0F, 0, 0, 0);
    step("R4 repeat ue",     0, 0, 0, 1, 22'h000001, 0, 0, 0);
    step("R5 write zero",    0, 0, 0, 0, 0, 1, 8'h80, 2'b00);
    step("R5 other offset",  0, 0, 0, 0, 0, 1, 8'hA0, 2'b11);
    step("R5 clear ce",      0, 0, 0, 0, 0, 1, 8'h80, 2'b01);
    step("R7 next set wins", 0, 0, 0, 1, 22'h0ABCDE, 1, 8'h82, 2'b11);
    step("R6 clear next",    0, 0, 0, 0, 0, 1, 8'h82, 2'b11);
    step("R10 lo zero",      1, 22'h155555, 16'h5A00, 0, 0, 0, 0, 0);
    step("R7 clear vs evt",  1, 22'h0FFFFF, 16'h1234, 0, 0, 1, 8'h80, 2'b01);
    step("R9 clear all f",   0, 0, 0, 0, 0, 1, 8'h80, 2'b11);
    step("R9 clear all n",   0, 0, 0, 0, 0, 1, 8'h82, 2'b11);
    step("R8 both",          1, 22'h3FFFFF, 16'h0A55, 1, 22'h200000, 0, 0, 0);
    step("R10 clr",          0, 0, 0, 0, 0, 1, 8'h80, 2'b11);
    step("R10 sub nibble",   1, 22'h000123, 16'hA055, 0, 0, 0, 0, 0);
    step("R10 clr2",         0, 0, 0, 0, 0, 1, 8'h80, 2'b01);
    step("R10 all set",      1, 22'h000456, 16'hABCD, 0, 0, 0, 0, 0);
    step("R10 clr3",         0, 0, 0, 0, 0, 1, 8'h80, 2'b01);
    step("R10 zero syn",     1, 22'h000789, 16'h0000, 0, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R4 R5 R6 R7 R8 mix", r[0] & r[1], 22'($urandom), 16'($urandom),
           r[2] & r[3], 22'($urandom), r[4],
           r[5] ? 8'h82 : (r[6] ? 8'h80 : 8'hD0), r[8:7]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule